// File: doc/BRIEF.md
# Flash Bus Write Qualifier

This block sits at the pin side of a parallel NOR-style flash device. It receives the three active-low control pins: chip enable, write enable and output enable. It also receives the address and data buses. A fast system clock samples all of these. From the samples the block decides when a real bus write has taken place.

A write window is open while chip enable and write enable are both low and output enable is high. The window opens when the later of the two enables falls, and the block latches the address at that moment. The window closes when the earlier of the two enables rises, and the block latches the data at that moment. After a valid close, the block raises a one-clock strobe for the downstream command decoder. The latched address and data appear on the outputs in the same cycle as the strobe.

Every control pin passes through a synchronizer and then a pulse-width filter, so short noise pulses cannot open or close a window. The minimum accepted width is given in nanoseconds and converted to clocks using the sampling rate. A flag set at reset blocks writes until the pins have shown a non-write combination. This prevents a write that is already in progress at power-up from being taken as a command.

Top module: `fwq_write_qual`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_stb` is 0 and `wr_addr`/`wr_data` are all zero.
- R2: A window requires `ce_n`=0, `we_n`=0 and `oe_n`=1 together, each held for at least the minimum width. Closing it by raising `ce_n` or `we_n` gives exactly one `wr_stb` pulse carrying the latched address and data.
- R3: The address reported is the value on `bus_addr` when the later of `ce_n`/`we_n` fell. Address changes after that point are not reported, and changes before it are superseded.
- R4: The data reported is the value on `bus_data` when the earlier of `ce_n`/`we_n` rose. Data changes after that rise have no effect.
- R5: If `oe_n` is 0 while both enables are low, no window opens and no strobe follows.
- R6: A low pulse on `we_n` or `ce_n` shorter than the minimum width produces no strobe. A high pulse shorter than the minimum width inside an open window does not split it. A pulse of exactly the minimum width is accepted.
- R7: If `ce_n`=0, `we_n`=0 and `oe_n`=1 are present at reset, the first release of `we_n` gives no strobe. The next complete write is accepted.
- R8: `wr_stb` is never high on two consecutive cycles. `wr_addr` and `wr_data` change only in a cycle where `wr_stb` is high.
- R9: The minimum width in clocks is ceil(`GLITCH_NS` × `SAMPLE_MHZ` / 1000), with a floor of 1. The defaults give 5 clocks.
- R10: If `oe_n` falls to 0 while a window is open, the window is abandoned and no strobe follows when the enables rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| bus_addr | input | ADDR_W | Address bus pins |
| bus_data | input | DATA_W | Data bus pins |
| wr_stb | output | 1 | One-clock pulse marking an accepted write |
| wr_addr | output | ADDR_W | Address of the accepted write, held between strobes |
| wr_data | output | DATA_W | Data of the accepted write, held between strobes |

## Verification
A filter counter stuck or off by one changes the cycle in which `wr_stb` appears. This shows within about ten clocks of the pin edge concerned. It also lets a sub-width pulse through, or rejects a pulse of exactly the minimum width. A window flag left open, or a power-up flag that never clears, shows up as a missing strobe or an extra one at the next enable release. A mis-timed capture register shows up at the next strobe as a wrong `wr_addr` or `wr_data`. The bench therefore compares all three outputs against a behavioural model on every clock, so any of these faults is reported in the cycle it reaches the ports.

// File: rtl/fwq_pkg.sv
package fwq_pkg;

    // control vector layout: bit 0 chip enable, bit 1 write enable, bit 2 output enable
    localparam int CE_IX = 0;
    localparam int WE_IX = 1;
    localparam int OE_IX = 2;
    localparam int NCTL  = 3;

    typedef logic [NCTL-1:0] ctl_t;

    // R9: nanosecond width to sampling clocks, rounded up, never below one
    function automatic int min_pulse_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fwq_pipe.sv
module fwq_pipe #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stg_q[i] <= RST_VAL;
            else     stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fwq_deglitch.sv
module fwq_deglitch #(
    parameter int   MIN_PULSE = 5,
    parameter logic RST_LVL   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (raw != s_q.level) begin
            if (s_q.cnt == CW'(MIN_PULSE - 1)) begin
                s_d.level = raw;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.level <= RST_LVL;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl = s_q.level;

    // independent run-length observer of input disagreeing with output
    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (raw == lvl)     run_q <= '0;
        else if (run_q != CW'(MIN_PULSE)) run_q <= run_q + CW'(1);
    end

    assert_min_width_R6: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> ($past(run_q) >= CW'(MIN_PULSE - 1)))
        else $error("output level flipped before minimum width");
endmodule

// File: rtl/fwq_write_qual.sv
module fwq_write_qual
    import fwq_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_NS   = 5,
    parameter int SAMPLE_MHZ  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int MIN_PULSE = min_pulse_cycles(GLITCH_NS, SAMPLE_MHZ);
    localparam int BUS_DEPTH = SYNC_STAGES + MIN_PULSE;
    localparam int SETTLE    = SYNC_STAGES + MIN_PULSE + 1;
    localparam int SW        = $clog2(SETTLE + 1);

    // ---------------- pin conditioning ----------------
    ctl_t ctl_raw, ctl_sync, ctl_flt;
    logic [ADDR_W-1:0] addr_dly;
    logic [DATA_W-1:0] data_dly;

    always_comb begin
        ctl_raw        = '1;
        ctl_raw[CE_IX] = ce_n;
        ctl_raw[WE_IX] = we_n;
        ctl_raw[OE_IX] = oe_n;
    end

    fwq_pipe #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL({NCTL{1'b1}})) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_sync));

    fwq_pipe #(.W(ADDR_W), .STAGES(BUS_DEPTH), .RST_VAL('0)) u_addr_dly (
        .clk(clk), .rst(rst), .d(bus_addr), .q(addr_dly));

    fwq_pipe #(.W(DATA_W), .STAGES(BUS_DEPTH), .RST_VAL('0)) u_data_dly (
        .clk(clk), .rst(rst), .d(bus_data), .q(data_dly));

    for (genvar g = 0; g < NCTL; g++) begin : g_flt
        fwq_deglitch #(.MIN_PULSE(MIN_PULSE), .RST_LVL(1'b1)) u_flt (
            .clk(clk), .rst(rst), .raw(ctl_sync[g]), .lvl(ctl_flt[g]));
    end

    // ---------------- window qualifier ----------------
    typedef struct packed {
        logic              win;
        logic              pu;
        logic [SW-1:0]     settle;
        logic [ADDR_W-1:0] addr_lat;
        logic              stb;
        logic [ADDR_W-1:0] out_addr;
        logic [DATA_W-1:0] out_data;
    } qual_t;

    qual_t q_q, q_d;
    logic  wr_ok;

    assign wr_ok = !ctl_flt[CE_IX] && !ctl_flt[WE_IX] && ctl_flt[OE_IX];

    always_comb begin
        q_d     = q_q;
        q_d.stb = 1'b0;
        if (q_q.settle != SW'(SETTLE)) q_d.settle = q_q.settle + SW'(1);
        if (q_q.pu && (q_q.settle == SW'(SETTLE)) && !wr_ok) q_d.pu = 1'b0;
        if (!q_q.win) begin
            if (wr_ok && !q_q.pu) begin
                q_d.win      = 1'b1;
                q_d.addr_lat = addr_dly;
            end
        end else if (!wr_ok) begin
            q_d.win = 1'b0;
            if (ctl_flt[OE_IX]) begin
                q_d.stb      = 1'b1;
                q_d.out_addr = q_q.addr_lat;
                q_d.out_data = data_dly;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q    <= '0;
            q_q.pu <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign wr_stb  = q_q.stb;
    assign wr_addr = q_q.out_addr;
    assign wr_data = q_q.out_data;

    // ---------------- assertions ----------------
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb)
        else $error("strobe longer than one clock");

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)))
        else $error("outputs moved without strobe");

    assert_oe_qualifies_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(ctl_flt[OE_IX]))
        else $error("strobe issued with output enable low");

    assert_powerup_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        q_q.pu |-> !q_q.win)
        else $error("window open during power-up inhibit");

    assert_stb_after_close_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(q_q.win) && !q_q.win))
        else $error("strobe without a closing window");
endmodule

// File: tb/fwq_write_qual_test.sv
`timescale 1ns/1ps
module fwq_write_qual_test;
    localparam int AW    = 20;
    localparam int DW    = 16;
    localparam int SYNCP = 2;
    localparam int MINP  = (5 * 1000 + 999) / 1000;  // R9 with defaults
    localparam int SETL  = SYNCP + MINP + 1;

    logic clk = 1'b0;
    logic rst;
    logic ce_n, we_n, oe_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    always #10 clk = ~clk;  // 50 MHz

    fwq_write_qual #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNCP),
                     .GLITCH_NS(5), .SAMPLE_MHZ(1000)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

    int    n_cmp  = 0;
    int    n_bad  = 0;
    string cur_req = "R1";
    bit    armed  = 0;
    bit    done   = 0;

    // ---------------- behavioural reference ----------------
    logic [2:0]    hist[$];   // {oe,we,ce} samples in flight
    logic [AW-1:0] ahist[$];
    logic [DW-1:0] dhist[$];
    bit   seen[3];
    int   run[3];
    bit   m_open, m_block, m_stb;
    int   m_age;
    logic [AW-1:0] m_alat, m_aout;
    logic [DW-1:0] m_dout;

    always @(posedge clk) begin
        if (rst) begin
            hist.delete(); ahist.delete(); dhist.delete();
            repeat (SYNCP) hist.push_back(3'b111);
            repeat (SYNCP + MINP) begin ahist.push_back('0); dhist.push_back('0); end
            foreach (seen[i]) begin seen[i] = 1; run[i] = 0; end
            m_open = 0; m_block = 1; m_stb = 0; m_age = 0;
            m_alat = '0; m_aout = '0; m_dout = '0;
        end else begin
            bit writable;
            logic [2:0] smp;
            writable = !seen[0] && !seen[1] && seen[2];
            m_stb = 0;
            if (m_block && m_age == SETL && !writable) m_block = 0;
            else if (m_age != SETL) m_age++;
            if (!m_open) begin
                if (writable && !m_block) begin m_open = 1; m_alat = ahist[0]; end
            end else if (!writable) begin
                m_open = 0;
                if (seen[2]) begin m_stb = 1; m_aout = m_alat; m_dout = dhist[0]; end
            end
            smp = hist[0];
            for (int i = 0; i < 3; i++) begin
                if (smp[i] != seen[i]) begin
                    if (run[i] == MINP - 1) begin seen[i] = smp[i]; run[i] = 0; end
                    else run[i]++;
                end else run[i] = 0;
            end
            void'(hist.pop_front());  hist.push_back({oe_n, we_n, ce_n});
            void'(ahist.pop_front()); ahist.push_back(bus_addr);
            void'(dhist.pop_front()); dhist.push_back(bus_data);
        end
    end

    // ---------------- per-clock comparison and strobe monitor ----------------
    int nstb = 0;
    logic [AW-1:0] last_a;
    logic [DW-1:0] last_d;
    bit prev_stb = 0;

    always @(negedge clk) begin
        if (armed && !rst) begin
            n_cmp++;
            if (wr_stb !== m_stb || wr_addr !== m_aout || wr_data !== m_dout) begin
                n_bad++;
                $display("FAIL %s per-clock: stb/addr/data actual %0b/%0h/%0h expected %0b/%0h/%0h",
                         cur_req, wr_stb, wr_addr, wr_data, m_stb, m_aout, m_dout);
            end
            if (wr_stb) begin nstb++; last_a = wr_addr; last_d = wr_data; end
            if (wr_stb && prev_stb) begin
                n_bad++;
                $display("FAIL R8 strobe width: actual 2+ expected 1");
            end
            prev_stb = wr_stb;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    int base;

    initial begin
        // R7: write combination already present at reset
        ce_n = 0; we_n = 0; oe_n = 1; bus_addr = 'h11111; bus_data = 'h1111;
        rst = 1;
        wait_n(3);
        rst = 0;
        armed = 1;
        @(negedge clk);
        chk("R1", "stb after reset", wr_stb, 0);
        chk("R1", "addr after reset", wr_addr, 0);
        chk("R1", "data after reset", wr_data, 0);
        cur_req = "R7";
        wait_n(20);
        we_n = 1;
        wait_n(20);
        chk("R7", "strobes on first release", nstb, 0);
        ce_n = 1;
        wait_n(15);
        // R7: next full write accepted; also R2 basic write controlled by we_n
        cur_req = "R2";
        base = nstb;
        bus_addr = 'h0A5A5; bus_data = 'hBEEF;
        ce_n = 0; wait_n(12);
        we_n = 0; wait_n(12);
        we_n = 1; wait_n(15);
        chk("R2", "strobe count", nstb - base, 1);
        chk("R2", "addr", last_a, 'h0A5A5);
        chk("R2", "data", last_d, 'hBEEF);
        chk("R7", "write after power-up release", nstb - base, 1);
        ce_n = 1; wait_n(15);

        // R3: we_n falls later; addr changes before and after that fall
        cur_req = "R3";
        base = nstb;
        bus_addr = 'h00001; ce_n = 0; wait_n(12);
        bus_addr = 'h12345; wait_n(12);
        we_n = 0; wait_n(12);
        bus_addr = 'h7FFFF; bus_data = 'h4242; wait_n(12);
        we_n = 1; wait_n(15);
        chk("R3", "addr at later fall (we_n)", last_a, 'h12345);
        chk("R3", "strobe count", nstb - base, 1);
        ce_n = 1; wait_n(15);
        // R3: ce_n falls later
        base = nstb;
        bus_addr = 'h00002; we_n = 0; wait_n(12);
        bus_addr = 'hABCDE; wait_n(12);
        ce_n = 0; wait_n(12);
        bus_addr = 'h00003; wait_n(12);
        ce_n = 1; wait_n(15);
        chk("R3", "addr at later fall (ce_n)", last_a, 'hABCDE);
        we_n = 1; wait_n(15);
        chk("R3", "no extra strobe on second rise", nstb - base, 1);

        // R4: data at earlier rise, later changes ignored
        cur_req = "R4";
        base = nstb;
        bus_addr = 'h00440; bus_data = 'h0001;
        ce_n = 0; we_n = 0; wait_n(12);
        bus_data = 'hC0DE; wait_n(12);
        ce_n = 1; wait_n(12);
        bus_data = 'hDEAD; wait_n(12);
        we_n = 1; wait_n(15);
        chk("R4", "data at earlier rise", last_d, 'hC0DE);
        chk("R4", "strobe count", nstb - base, 1);

        // R5: oe_n low during overlap
        cur_req = "R5";
        base = nstb;
        oe_n = 0; ce_n = 0; we_n = 0; wait_n(15);
        we_n = 1; ce_n = 1; wait_n(15);
        oe_n = 1; wait_n(15);
        chk("R5", "strobes with oe_n low", nstb - base, 0);

        // R10: oe_n drops inside open window
        cur_req = "R10";
        base = nstb;
        ce_n = 0; we_n = 0; wait_n(12);
        oe_n = 0; wait_n(12);
        we_n = 1; ce_n = 1; wait_n(12);
        oe_n = 1; wait_n(15);
        chk("R10", "strobes after abandoned window", nstb - base, 0);

        // R6 / R9: short low pulses rejected, exact width accepted
        cur_req = "R6";
        ce_n = 0; wait_n(12);
        base = nstb;
        we_n = 0; wait_n(MINP - 2); we_n = 1; wait_n(15);
        chk("R6", "strobes for short we_n pulse", nstb - base, 0);
        we_n = 0; wait_n(MINP - 1); we_n = 1; wait_n(15);
        chk("R9", "strobes for width-1 pulse", nstb - base, 0);
        bus_addr = 'h05555; bus_data = 'h5A5A;
        we_n = 0; wait_n(MINP); we_n = 1; wait_n(15);
        chk("R9", "strobes for exact-width pulse", nstb - base, 1);
        chk("R6", "exact-width addr", last_a, 'h05555);
        ce_n = 1; wait_n(15);
        // short ce_n low pulse with we_n low
        base = nstb;
        we_n = 0; wait_n(12);
        ce_n = 0; wait_n(MINP - 1); ce_n = 1; wait_n(15);
        chk("R6", "strobes for short ce_n pulse", nstb - base, 0);
        // short high glitch inside window
        ce_n = 0; wait_n(12);
        we_n = 1; wait_n(MINP - 2); we_n = 0; wait_n(12);
        chk("R6", "high glitch does not close window", nstb - base, 0);
        we_n = 1; wait_n(15);
        chk("R6", "one strobe for glitched window", nstb - base, 1);
        idle_pins(); wait_n(15);

        // R8: back-to-back writes, outputs hold between
        cur_req = "R8";
        base = nstb;
        for (int k = 0; k < 4; k++) begin
            bus_addr = AW'(k * 'h111 + 7); bus_data = DW'(k * 'h1010 + 3);
            ce_n = 0; we_n = 0; wait_n(MINP + 3);
            we_n = 1; ce_n = 1; wait_n(MINP + 4);
        end
        wait_n(10);
        chk("R8", "strobes for four writes", nstb - base, 4);
        chk("R8", "last addr held", wr_addr, 3 * 'h111 + 7);
        chk("R8", "last data held", wr_data, 3 * 'h1010 + 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule